// File: doc/BRIEF.md
# Hashed Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a fixed number of 2-bit saturating counters. A fetch address selects one counter through a hash. Any number of program branches share that table, because an entry carries no tag. A shared entry is simply reused by whichever branch hashes to it.

The lookup port takes the fetch PC and returns a taken/not-taken guess in the same cycle, with no register on the path. Once a branch resolves, the update port receives that branch's PC and its real outcome. The selected counter then moves one step toward that outcome on the next clock edge. The block does not compute targets, decode instructions or flush the pipeline.

Top module: `hashed_bimodal_pred`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not-taken), so every lookup predicts not-taken until it is trained.
- R2: An update with `upd_taken`=1 adds one to the selected counter.
- R3: An update with `upd_taken`=0 subtracts one from the selected counter.
- R4: `lkp_taken` equals bit 1 of the counter that `lkp_pc` selects, and it follows `lkp_pc` combinationally in the same cycle.
- R5: A counter at 2'b11 stays at 2'b11 when it is updated as taken.
- R6: A counter at 2'b00 stays at 2'b00 when it is updated as not-taken.
- R7: The entry index is the low IDX_W bits of (PC >> 2) XOR (PC >> 12). There is no tag, so two PCs with equal index bits share one counter. For example, with IDX_W=10, PCs that differ only in bits 2 and 12 share a counter.
- R8: If a lookup and an update select the same entry in one cycle, the lookup returns the value from before the update. The updated value is visible after the next rising clock edge.
- R9: While `upd_valid` is 0, no counter changes, whatever `upd_pc` and `upd_taken` carry.
- R10: An update changes only the entry it selects. Lookups of other entries are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | 32 | Fetch PC to predict |
| lkp_taken | output | 1 | Prediction: 1 means taken |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
On every cycle, the assertions check how the written counter steps. They check increment, decrement, holding at either end, and that the table stays unchanged when no update is presented. Other properties span several events, and only the bench's scenarios can show them. These are:
- the reset value, seen through the first training step;
- the exact hash, with aliasing between PCs;
- isolation of neighbouring entries;
- the old-value result when a lookup and an update collide on one entry.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    localparam int PC_W      = 32;
    localparam int SHIFT_LO  = 2;
    localparam int SHIFT_HI  = 12;
endpackage

// File: rtl/bp_index_hash.sv
module bp_index_hash
    import bp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    logic [PC_W-1:0] mixed;
    logic            unused_mix_hi;

    // Fold two shifted copies of the PC together; keep the low bits.
    always_comb begin
        mixed = (pc >> SHIFT_LO) ^ (pc >> SHIFT_HI);
        idx   = mixed[IDX_W-1:0];
    end

    assign unused_mix_hi = ^mixed[PC_W-1:IDX_W];
endmodule

// File: rtl/bp_sat_step.sv
module bp_sat_step
    import bp_pkg::*;
(
    input  ctr_t cur,
    input  logic up,
    output ctr_t nxt
);
    always_comb begin
        nxt = cur;
        if (up) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
    end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    typedef struct packed {
        ctr_t [DEPTH-1:0] ent;
    } tbl_t;

    tbl_t st_d, st_q;
    ctr_t cur_ctr;
    ctr_t step_ctr;

    assign cur_ctr = st_q.ent[wr_idx];

    bp_sat_step u_step (
        .cur (cur_ctr),
        .up  (wr_taken),
        .nxt (step_ctr)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ent[wr_idx] = step_ctr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q.ent[i] <= CTR_WEAK_NT;
        end else begin
            st_q <= st_d;
        end
    end

    // Read sees the registered table only: a same-cycle write is not bypassed.
    assign rd_taken = st_q.ent[rd_idx][1];

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && cur_ctr != CTR_STRONG_T)
        |=> st_q.ent[$past(wr_idx)] == $past(cur_ctr) + 2'd1); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && cur_ctr != CTR_STRONG_NT)
        |=> st_q.ent[$past(wr_idx)] == $past(cur_ctr) - 2'd1); // R3
    AST_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && cur_ctr == CTR_STRONG_T)
        |=> st_q.ent[$past(wr_idx)] == CTR_STRONG_T); // R5
    AST_HOLD_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && cur_ctr == CTR_STRONG_NT)
        |=> st_q.ent[$past(wr_idx)] == CTR_STRONG_NT); // R6
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R9
endmodule

// File: rtl/hashed_bimodal_pred.sv
module hashed_bimodal_pred
    import bp_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lkp_pc,
    output logic        lkp_taken,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic        upd_taken
);
    logic [IDX_W-1:0] lkp_idx;
    logic [IDX_W-1:0] upd_idx;

    bp_index_hash #(.IDX_W(IDX_W)) u_hash_lkp (
        .pc  (lkp_pc),
        .idx (lkp_idx)
    );

    bp_index_hash #(.IDX_W(IDX_W)) u_hash_upd (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    bp_ctr_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lkp_idx),
        .rd_taken (lkp_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );
endmodule

// File: tb/sim_hashed_bimodal_pred.sv
module sim_hashed_bimodal_pred;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lkp_pc = '0;
    logic        lkp_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hashed_bimodal_pred u0 (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic exp);
        lkp_pc = pc;
        #1;
        check(req, lkp_taken, exp);
    endtask

    task automatic train(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        look("R1 reset pc0", 32'h0000_0000, 1'b0);
        look("R1 reset pcA", 32'h0040_1234, 1'b0);
        look("R1 reset pcB", 32'hFFFF_FFFC, 1'b0);
        train(32'h0000_0100, 1'b1);
        look("R1 R2 one taken from 01", 32'h0000_0100, 1'b1);
    endtask

    task automatic t_saturate_high();
        logic [31:0] pc = 32'h0000_2040;
        for (int i = 0; i < 5; i++) train(pc, 1'b1);
        look("R2 R4 trained taken", pc, 1'b1);
        train(pc, 1'b0);
        look("R5 R3 still taken after one NT", pc, 1'b1);
        train(pc, 1'b0);
        look("R3 second NT flips", pc, 1'b0);
    endtask

    task automatic t_saturate_low();
        logic [31:0] pc = 32'h0001_8888;
        for (int i = 0; i < 4; i++) train(pc, 1'b0);
        look("R3 trained NT", pc, 1'b0);
        train(pc, 1'b1);
        look("R6 one taken from floor", pc, 1'b0);
        train(pc, 1'b1);
        look("R6 second taken flips", pc, 1'b1);
    endtask

    task automatic t_alias();
        logic [31:0] p1 = 32'h0000_5000;
        logic [31:0] p2 = p1 ^ 32'h0000_1004;
        logic [31:0] p3 = p1 ^ 32'h0000_0004;
        look("R7 alias partner untrained", p2, 1'b0);
        train(p1, 1'b1);
        look("R7 alias partner shares counter", p2, 1'b1);
        look("R10 neighbour untouched", p3, 1'b0);
        // 0x3008: (pc>>2)=0xC02, (pc>>12)=0x3 -> index 0x001; 0x0004 -> index 0x001
        train(32'h0000_3008, 1'b1);
        look("R7 hash equal index", 32'h0000_0004, 1'b1);
    endtask

    task automatic t_collide();
        logic [31:0] pc = 32'h0007_0010;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = 1'b1;
        look("R8 old value during update", pc, 1'b0);
        @(negedge clk);
        upd_valid = 1'b0;
        look("R8 new value after edge", pc, 1'b1);
    endtask

    task automatic t_idle();
        logic [31:0] pc = 32'h00A0_0200;
        @(negedge clk);
        upd_valid = 1'b0; upd_pc = pc; upd_taken = 1'b1;
        repeat (4) @(negedge clk);
        look("R9 no change while invalid", pc, 1'b0);
        upd_taken = 1'b0;
        train(pc, 1'b1);
        look("R9 control: valid update applies", pc, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_saturate_high();
        t_saturate_low();
        t_alias();
        t_collide();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule